// File: doc/BRIEF.md
# Reflex Game Sequencer

This block sequences a stop-at-zero reflex game. A player starts a countdown timer and then tries to stop it as close to zero as possible. The block takes single-cycle button pulses for start/stop, store, skip, clear and display advance. It steers the countdown timer through three phases: waiting at 10.00, counting and frozen. The hundredth-second tick reaches the timer only while the game is counting.

Once the timer is frozen, the player either saves the result into the result storage or throws it away. Either choice returns the timer to its start value. A clear pulse empties the storage and restarts the game at any point. A separate wrap-around counter selects which value the display shows: the live count, the last saved result, the smallest magnitude or the largest magnitude. A bar of LEDs shows the selected view.

Top module: `reflex_ctrl`

## Requirements
- R1: After reset the game waits: `tmr_init_o` is 1, `tmr_en_o` is 0, `mode_o` is 0 (live count) and `led_o` is 8'b0000_0001.
- R2: A start pulse while waiting moves the game to counting on the next edge, and `tmr_init_o` drops to 0.
- R3: `tmr_en_o` follows `tick_i` in the same cycle only while counting. It is 0 while waiting or frozen.
- R4: While counting, a start pulse freezes the game on the next edge. A 1 on `at_min_i` also freezes it on the next edge.
- R5: While frozen, a store pulse gives `res_store_o` = 1 in that same cycle, and the game returns to waiting with `tmr_init_o` = 1 on the next edge. If store and skip come together, store wins.
- R6: While frozen, a skip pulse returns the game to waiting on the next edge without raising `res_store_o`.
- R7: Store and skip have no effect unless the game is frozen. A start pulse while frozen has no effect.
- R8: A clear pulse gives `res_clear_o` = 1 in that cycle and returns the game to waiting on the next edge. It overrides any start, store, skip or next pulse in the same cycle: `res_store_o` stays 0 and the mode does not move.
- R9: Each next pulse advances `mode_o` on the next edge through 0 (live), 1 (last stored), 2 (minimum), 3 (maximum) and then back to 0.
- R10: `led_o` lights bits 0 through `mode_o` and leaves every higher bit dark, so mode 0 lights one LED and mode 3 lights four.
- R11: Clear leaves `mode_o` unchanged. Only reset returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start/stop button pulse |
| store_i | input | 1 | Store button pulse |
| skip_i | input | 1 | Skip button pulse |
| clear_i | input | 1 | Clear button pulse |
| next_i | input | 1 | Display advance button pulse |
| tick_i | input | 1 | Hundredth-second tick |
| at_min_i | input | 1 | Timer has reached its lowest value |
| tmr_init_o | output | 1 | Hold the timer at 10.00 |
| tmr_en_o | output | 1 | Gated tick to the timer |
| res_store_o | output | 1 | Save the frozen result |
| res_clear_o | output | 1 | Empty the result storage |
| mode_o | output | 2 | Display view select |
| led_o | output | 8 | LED bar showing the view |

## Verification
The bench builds the block with its default values: four display views and eight LEDs. With these values the full wrap of the view counter is reachable, and the four upper LEDs can be checked to stay dark in every view. The vector table walks the game through every phase and every button in every phase, including coincident pulses in which clear or store has to win. Directed tests then check a reset in the middle of a game while a non-zero view is selected.

// File: rtl/reflex_pkg.sv
package reflex_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COUNT = 2'd1,
    ST_FROZE = 2'd2
  } game_st_e;
endpackage

// File: rtl/reflex_fsm.sv
module reflex_fsm
  import reflex_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic store_i,
  input  logic skip_i,
  input  logic clear_i,
  input  logic tick_i,
  input  logic at_min_i,
  output logic tmr_init_o,
  output logic tmr_en_o,
  output logic res_store_o,
  output logic res_clear_o
);
  game_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clear_i) st_d = ST_WAIT;
    else begin
      unique case (st_q)
        ST_WAIT:  if (start_i) st_d = ST_COUNT;
        ST_COUNT: if (start_i || at_min_i) st_d = ST_FROZE;
        ST_FROZE: if (store_i || skip_i) st_d = ST_WAIT;
        default:  st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_WAIT;
    else         st_q <= st_d;

  assign tmr_init_o  = (st_q == ST_WAIT);
  assign tmr_en_o    = (st_q == ST_COUNT) && tick_i;
  assign res_store_o = (st_q == ST_FROZE) && store_i && !clear_i;
  assign res_clear_o = clear_i;

  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && start_i && !clear_i) |=> (st_q == ST_COUNT)); // R2
  AST_STOP_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COUNT && (start_i || at_min_i) && !clear_i) |=> (st_q == ST_FROZE)); // R4
  AST_STORE_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_store_o |=> tmr_init_o); // R5
  AST_FROZEN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FROZE && !store_i && !skip_i && !clear_i) |=> (st_q == ST_FROZE)); // R7
  AST_CLEAR_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> tmr_init_o); // R8
  AST_GATED_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_en_o |-> !tmr_init_o); // R3
endmodule

// File: rtl/reflex_mode_cnt.sv
module reflex_mode_cnt #(
  parameter int NUM_MODES = 4,
  localparam int MODE_W = $clog2(NUM_MODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              next_i,
  input  logic              clear_i,
  output logic [MODE_W-1:0] mode_o
);
  localparam logic [MODE_W-1:0] LAST = MODE_W'(NUM_MODES - 1);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= '0;
    else if (next_i && !clear_i) mode_q <= (mode_q == LAST) ? '0 : mode_q + 1'b1;

  assign mode_o = mode_q;

  AST_MODE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !clear_i && mode_q != LAST) |=> (mode_q == $past(mode_q) + 1'b1)); // R9
  AST_MODE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_i && !clear_i && mode_q == LAST) |=> (mode_q == '0)); // R9
  AST_CLEAR_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> $stable(mode_q)); // R11
endmodule

// File: rtl/reflex_led_bar.sv
module reflex_led_bar #(
  parameter int MODE_W = 2,
  parameter int LED_W  = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [LED_W-1:0]  led_o
);
  for (genvar g = 0; g < LED_W; g++) begin : g_led
    assign led_o[g] = (32'(mode_i) >= g);
  end

  always_comb
    AST_LED_COUNT: assert ($countones(led_o) == 32'(mode_i) + 1); // R10
endmodule

// File: rtl/reflex_ctrl.sv
module reflex_ctrl #(
  parameter int NUM_MODES = 4,
  parameter int LED_W     = 8,
  localparam int MODE_W   = $clog2(NUM_MODES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              store_i,
  input  logic              skip_i,
  input  logic              clear_i,
  input  logic              next_i,
  input  logic              tick_i,
  input  logic              at_min_i,
  output logic              tmr_init_o,
  output logic              tmr_en_o,
  output logic              res_store_o,
  output logic              res_clear_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [LED_W-1:0]  led_o
);
  reflex_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .store_i     (store_i),
    .skip_i      (skip_i),
    .clear_i     (clear_i),
    .tick_i      (tick_i),
    .at_min_i    (at_min_i),
    .tmr_init_o  (tmr_init_o),
    .tmr_en_o    (tmr_en_o),
    .res_store_o (res_store_o),
    .res_clear_o (res_clear_o)
  );

  reflex_mode_cnt #(.NUM_MODES(NUM_MODES)) u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .next_i  (next_i),
    .clear_i (clear_i),
    .mode_o  (mode_o)
  );

  reflex_led_bar #(.MODE_W(MODE_W), .LED_W(LED_W)) u_led (
    .mode_i (mode_o),
    .led_o  (led_o)
  );

  AST_RESET_VIEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (led_o[0] && tmr_init_o)); // R1
endmodule

// File: tb/reflex_ctrl_test.sv
module reflex_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, store_i = 0, skip_i = 0, clear_i = 0, next_i = 0, tick_i = 0, at_min_i = 0;
  logic tmr_init_o, tmr_en_o, res_store_o, res_clear_o;
  logic [1:0] mode_o;
  logic [7:0] led_o;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  reflex_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .store_i(store_i), .skip_i(skip_i),
    .clear_i(clear_i), .next_i(next_i), .tick_i(tick_i), .at_min_i(at_min_i),
    .tmr_init_o(tmr_init_o), .tmr_en_o(tmr_en_o), .res_store_o(res_store_o),
    .res_clear_o(res_clear_o), .mode_o(mode_o), .led_o(led_o)
  );

  // bits: start store skip clear next tick atmin | e_store e_clear e_en | e_init | e_mode
  localparam int NV = 26;
  localparam logic [12:0] VEC [NV] = '{
    13'b0000010_000_1_00, // R3 tick while waiting blocked
    13'b1000000_000_0_00, // R2 start
    13'b0000010_001_0_00, // R3 tick passes
    13'b0100010_001_0_00, // R7 store while counting ignored
    13'b0010000_000_0_00, // R7 skip while counting ignored
    13'b1000000_000_0_00, // R4 stop
    13'b0000010_000_0_00, // R3 tick frozen blocked
    13'b1000000_000_0_00, // R7 start while frozen ignored
    13'b0100000_100_1_00, // R5 store
    13'b0000100_000_1_01, // R9 next
    13'b0100000_000_1_01, // R7 store while waiting ignored
    13'b1000000_000_0_01, // R2 start
    13'b0000011_001_0_01, // R4 at_min freezes
    13'b0010000_000_1_01, // R6 skip
    13'b0010000_000_1_01, // R7 skip while waiting ignored
    13'b1000000_000_0_01, // R2 start
    13'b1001100_010_1_01, // R8 clear beats start and next
    13'b0000100_000_1_10, // R9
    13'b0000100_000_1_11, // R9
    13'b0000100_000_1_00, // R9 wrap
    13'b1000000_000_0_00, // R2
    13'b1000000_000_0_00, // R4
    13'b0101000_010_1_00, // R8 clear suppresses store
    13'b1000000_000_0_00, // R2
    13'b1000000_000_0_00, // R4
    13'b0110000_100_1_00  // R5 store wins over skip
  };

  function automatic logic [7:0] exp_led(input logic [1:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i <= int'(m));
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_zero();
    {start_i, store_i, skip_i, clear_i, next_i, tick_i, at_min_i} = '0;
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 init", tmr_init_o, 1);
    check("R1 mode", mode_o, 0);
    check("R1 led", led_o, 8'h01);
    check("R1 en", tmr_en_o, 0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {start_i, store_i, skip_i, clear_i, next_i, tick_i, at_min_i} = VEC[k][12:6];
      #1;
      check($sformatf("R5/R8 store v%0d", k), res_store_o, VEC[k][5]);
      check($sformatf("R8 clear v%0d", k), res_clear_o, VEC[k][4]);
      check($sformatf("R3 en v%0d", k), tmr_en_o, VEC[k][3]);
      @(posedge clk);
      #1;
      check($sformatf("R2/R4 init v%0d", k), tmr_init_o, VEC[k][2]);
      check($sformatf("R9/R11 mode v%0d", k), mode_o, VEC[k][1:0]);
      check($sformatf("R10 led v%0d", k), led_o, exp_led(VEC[k][1:0]));
    end

    // directed: reset mid game with non-zero view
    @(negedge clk); drive_zero(); next_i = 1;
    @(negedge clk); next_i = 0; start_i = 1;
    @(negedge clk); start_i = 0;
    #1;
    check("R9 mode before reset", mode_o, 1);
    check("R2 counting before reset", tmr_init_o, 0);
    rst_ni = 1'b0;
    #1;
    check("R1 init after reset", tmr_init_o, 1);
    check("R11 mode only reset", mode_o, 0);
    check("R1 led after reset", led_o, 8'h01);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); tick_i = 1; #1;
    check("R3 tick after reset", tmr_en_o, 0);
    tick_i = 0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule